// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Register Front-End

This block sits between a simple register bus and a small behavioural model of an on-chip non-volatile array. Software first selects an access mode: read-only, word programming or erasing. It then programs single 32-bit words or erases a page, the whole array, or the separate information area. During each operation the block stays busy for a fixed, parameterised number of clock cycles. Software is expected to poll a ready flag until it returns to 1 before it issues the next operation.

The array follows flash semantics. Erased storage reads back as all ones. A program operation can only clear bits, so the stored word becomes the old value ANDed with the written value. Any request made in the wrong access mode, or while an operation is still running, is dropped. Such a request leaves both the array and the busy state unchanged.

The bus uses one address space. The register window begins at the top bit of the address, so register offset X lives at byte address 0x8000 + X. The main array starts at byte address 0. The information area starts at byte address 0x1000. Read data is registered.

Top module: `flash_controller`

## Requirements
- R1: After reset both ready flags read 1, the access mode reads 0, and every word of the main array and the information area reads 0xFFFFFFFF.
- R2: Bits [1:0] of a write to offset 0x504 set the access mode (0 read-only, 1 program, 2 erase, 3 treated as read-only). A read of 0x504 returns the mode in bits [1:0] and zeros in all other bits.
- R3: In program mode with the block idle, a write to a main-array or information-area word address stores the old contents ANDed with the written data.
- R4: Ready, read at offset 0x400 and at the mirror offset 0x408 in bit 0, reads 0 for exactly PROG_CYCLES consecutive polls after an accepted word program.
- R5: In erase mode with the block idle, writing a main-array byte address to offset 0x508 sets every word of the page holding that address to all ones. Other pages keep their contents, and ready reads 0 for exactly PAGE_CYCLES polls. An address beyond the main array starts nothing.
- R6: In erase mode with the block idle, writing a value with bit 0 set to offset 0x50C erases the main array and the information area, and ready reads 0 for exactly FULL_CYCLES polls. A value with bit 0 clear starts nothing.
- R7: In erase mode with the block idle, writing a value with bit 0 set to offset 0x514 erases only the information area, and ready reads 0 for PAGE_CYCLES polls. The main array is left unchanged.
- R8: A program request outside program mode, or an erase request outside erase mode, is ignored: ready stays 1 and the array is unchanged.
- R9: Any program or erase request that arrives while ready reads 0 is ignored.
- R10: Read data for the address presented before a clock edge appears on the read-data port after that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address; the top bit selects the register window |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one write per cycle |
| busRdata | output | 32 | Registered read data |

## Verification
The hardest case to reach is a request that lands while an operation is still running. Software that polls correctly never issues one. To create it, the bench sends a second program or erase on the very next clock edge after an accepted one, before any poll. It then checks that the remaining busy window is unchanged and that the target word kept its contents. Busy lengths are counted poll by poll against the parameters for every word, page and area. The bench holds a shadow array and updates it with AND on programs and with ones on erases, so both the dropped requests and the accepted ones are checked against it.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_ERASE = 2'd2,
    MODE_RSVD  = 2'd3
  } accMode_e;

  localparam logic [11:0] OFF_READY     = 12'h400;
  localparam logic [11:0] OFF_READY_ALT = 12'h408;
  localparam logic [11:0] OFF_CFG       = 12'h504;
  localparam logic [11:0] OFF_PG_ERASE  = 12'h508;
  localparam logic [11:0] OFF_ALL_ERASE = 12'h50C;
  localparam logic [11:0] OFF_INF_ERASE = 12'h514;

  // strobes issued by control to the datapath, one cycle wide
  typedef struct packed {
    logic        progMain;
    logic        progInfo;
    logic        erasePage;
    logic        eraseAll;
    logic        eraseInfo;
    logic [15:0] wordIdx;
    logic [15:0] pageIdx;
    logic [31:0] data;
  } opStrobe_t;

endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BYTES  = 32,
  parameter int NUM_PAGES   = 4,
  parameter int INFO_BASE   = 'h1000,
  parameter int INFO_BYTES  = 16,
  parameter int PROG_CYCLES = 4,
  parameter int PAGE_CYCLES = 32,
  parameter int FULL_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  output accMode_e          mode,
  output logic              busy,
  output opStrobe_t         strb
);

  localparam int MAIN_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam int MAX_CYC    = (FULL_CYCLES > PAGE_CYCLES)
                              ? ((FULL_CYCLES > PROG_CYCLES) ? FULL_CYCLES : PROG_CYCLES)
                              : ((PAGE_CYCLES > PROG_CYCLES) ? PAGE_CYCLES : PROG_CYCLES);
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int PAGE_SH    = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(1) << (ADDR_W - 1);

  logic [CNT_W-1:0] busyCnt;
  logic inMain, inInfo, regWin;
  logic anyStart;

  assign regWin = busAddr[ADDR_W-1];
  assign inMain = !regWin && (32'(busAddr) < MAIN_BYTES);
  assign inInfo = !regWin && (32'(busAddr) >= INFO_BASE)
                  && (32'(busAddr) < INFO_BASE + INFO_BYTES);

  function automatic logic hitReg(input logic [ADDR_W-1:0] a, input logic [11:0] off);
    return a == (REG_BASE | ADDR_W'(off));
  endfunction

  always_comb begin
    strb = '0;
    strb.data    = busWdata;
    strb.wordIdx = inInfo ? 16'((32'(busAddr) - INFO_BASE) >> 2)
                          : 16'(32'(busAddr) >> 2);
    strb.pageIdx = 16'(busWdata >> PAGE_SH);
    if (busWe && !busy) begin
      if (mode == MODE_PROG) begin
        strb.progMain = inMain;
        strb.progInfo = inInfo;
      end
      if (mode == MODE_ERASE) begin
        strb.erasePage = hitReg(busAddr, OFF_PG_ERASE) && (busWdata < 32'(MAIN_BYTES));
        strb.eraseAll  = hitReg(busAddr, OFF_ALL_ERASE) && busWdata[0];
        strb.eraseInfo = hitReg(busAddr, OFF_INF_ERASE) && busWdata[0];
      end
    end
  end

  assign anyStart = strb.progMain | strb.progInfo | strb.erasePage
                  | strb.eraseAll | strb.eraseInfo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MODE_READ;
    end else if (busWe && hitReg(busAddr, OFF_CFG)) begin
      mode <= accMode_e'(busWdata[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (anyStart) begin
      if (strb.eraseAll)
        busyCnt <= CNT_W'(FULL_CYCLES);
      else if (strb.erasePage || strb.eraseInfo)
        busyCnt <= CNT_W'(PAGE_CYCLES);
      else
        busyCnt <= CNT_W'(PROG_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

endmodule

// File: rtl/flash_datapath.sv
module flash_datapath
  import flash_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 4,
  parameter int INFO_BASE  = 'h1000,
  parameter int INFO_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  accMode_e          mode,
  input  logic              busy,
  input  opStrobe_t         strb,
  output logic [31:0]       busRdata
);

  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int MAIN_WORDS = PAGE_WORDS * NUM_PAGES;
  localparam int INFO_WORDS = INFO_BYTES / 4;
  localparam int MAIN_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(1) << (ADDR_W - 1);

  logic [31:0] mainMem [MAIN_WORDS];
  logic [31:0] infoMem [INFO_WORDS];
  logic [31:0] rdNext;

  // main array: program clears bits, erase restores ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < MAIN_WORDS; w++) mainMem[w] <= '1;
    end else begin
      if (strb.progMain)
        mainMem[strb.wordIdx] <= mainMem[strb.wordIdx] & strb.data;
      for (int w = 0; w < MAIN_WORDS; w++) begin
        if (strb.eraseAll || (strb.erasePage && (32'(strb.pageIdx) == w / PAGE_WORDS)))
          mainMem[w] <= '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < INFO_WORDS; w++) infoMem[w] <= '1;
    end else begin
      if (strb.progInfo)
        infoMem[strb.wordIdx] <= infoMem[strb.wordIdx] & strb.data;
      if (strb.eraseAll || strb.eraseInfo)
        for (int w = 0; w < INFO_WORDS; w++) infoMem[w] <= '1;
    end
  end

  always_comb begin
    rdNext = '0;
    if (busAddr[ADDR_W-1]) begin
      if (busAddr == (REG_BASE | ADDR_W'(OFF_READY)) ||
          busAddr == (REG_BASE | ADDR_W'(OFF_READY_ALT)))
        rdNext = {31'd0, !busy};
      else if (busAddr == (REG_BASE | ADDR_W'(OFF_CFG)))
        rdNext = {30'd0, mode};
    end else if (32'(busAddr) < MAIN_BYTES) begin
      rdNext = mainMem[32'(busAddr) >> 2];
    end else if ((32'(busAddr) >= INFO_BASE) && (32'(busAddr) < INFO_BASE + INFO_BYTES)) begin
      rdNext = infoMem[(32'(busAddr) - INFO_BASE) >> 2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

endmodule

// File: rtl/flash_controller.sv
module flash_controller
  import flash_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BYTES  = 32,
  parameter int NUM_PAGES   = 4,
  parameter int INFO_BASE   = 'h1000,
  parameter int INFO_BYTES  = 16,
  parameter int PROG_CYCLES = 4,
  parameter int PAGE_CYCLES = 32,
  parameter int FULL_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  output logic [31:0]       busRdata
);

  accMode_e  mode;
  logic      busy;
  opStrobe_t strb;

  flash_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
    .INFO_BASE(INFO_BASE), .INFO_BYTES(INFO_BYTES),
    .PROG_CYCLES(PROG_CYCLES), .PAGE_CYCLES(PAGE_CYCLES), .FULL_CYCLES(FULL_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .mode(mode), .busy(busy), .strb(strb)
  );

  flash_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
    .INFO_BASE(INFO_BASE), .INFO_BYTES(INFO_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .mode(mode),
    .busy(busy), .strb(strb), .busRdata(busRdata)
  );

endmodule

// File: rtl/flash_checker.sv
module flash_checker
  import flash_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PROG_CYCLES = 4,
  parameter int PAGE_CYCLES = 32,
  parameter int FULL_CYCLES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input accMode_e          mode,
  input logic              busy,
  input opStrobe_t         strb
);

  localparam logic [ADDR_W-1:0] CFG_ADDR = (ADDR_W'(1) << (ADDR_W - 1)) | ADDR_W'(OFF_CFG);

  logic        started;
  logic [31:0] expLen;
  logic [31:0] runLen;

  assign started = strb.progMain | strb.progInfo | strb.erasePage
                 | strb.eraseAll | strb.eraseInfo;

  // busy-window length tracked by counter rather than a long $past
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expLen <= '0;
      runLen <= '0;
    end else if (started) begin
      expLen <= strb.eraseAll ? FULL_CYCLES
              : (strb.erasePage || strb.eraseInfo) ? PAGE_CYCLES : PROG_CYCLES;
      runLen <= '0;
    end else if (busy) begin
      runLen <= runLen + 1;
    end
  end

  assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    started |=> busy);

  assert_busy_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runLen == expLen);

  assert_busy_drops_requests_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !started);

  assert_prog_mode_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.progMain || strb.progInfo) |-> mode == MODE_PROG);

  assert_erase_mode_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.erasePage || strb.eraseAll || strb.eraseInfo) |-> mode == MODE_ERASE);

  assert_one_op_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.progMain, strb.progInfo, strb.erasePage, strb.eraseAll, strb.eraseInfo}));

  assert_cfg_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == CFG_ADDR) |=> busRdata[31:2] == '0);

endmodule

bind flash_controller flash_checker #(
  .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES),
  .PAGE_CYCLES(PAGE_CYCLES), .FULL_CYCLES(FULL_CYCLES)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdata(busRdata),
  .mode(mode), .busy(busy), .strb(strb)
);

// File: tb/tb_flash_controller.sv
module tb_flash_controller;

  localparam int CLK_PERIOD  = 10;
  localparam int PAGE_BYTES  = 32;
  localparam int NUM_PAGES   = 4;
  localparam int PAGE_WORDS  = PAGE_BYTES / 4;
  localparam int MAIN_WORDS  = PAGE_WORDS * NUM_PAGES;
  localparam int INFO_BYTES  = 16;
  localparam int INFO_WORDS  = INFO_BYTES / 4;
  localparam int INFO_BASE   = 'h1000;
  localparam int PROG_CYCLES = 4;
  localparam int PAGE_CYCLES = 32;
  localparam int FULL_CYCLES = 64;
  localparam logic [15:0] R_READY = 16'h8400;
  localparam logic [15:0] R_READY2 = 16'h8408;
  localparam logic [15:0] R_CFG   = 16'h8504;
  localparam logic [15:0] R_PGER  = 16'h8508;
  localparam logic [15:0] R_ALLER = 16'h850C;
  localparam logic [15:0] R_INFER = 16'h8514;

  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 0;
  logic [31:0] busRdata;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] expMain [MAIN_WORDS];
  logic [31:0] expInfo [INFO_WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_controller #(
    .ADDR_W(16), .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
    .INFO_BASE(INFO_BASE), .INFO_BYTES(INFO_BYTES),
    .PROG_CYCLES(PROG_CYCLES), .PAGE_CYCLES(PAGE_CYCLES), .FULL_CYCLES(FULL_CYCLES)
  ) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic busWrite(input logic [15:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1;
    @(posedge clk); @(negedge clk);
    busWe = 0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [31:0] d);
    busAddr = a; busWe = 0;
    @(posedge clk); @(negedge clk);
    d = busRdata;
  endtask

  task automatic pollBusy(output int cnt);
    logic [31:0] d;
    cnt = 0;
    for (int i = 0; i < 2000; i++) begin
      busRead(R_READY, d);
      if (d[0]) break;
      cnt++;
    end
  endtask

  task automatic checkArray(input string req);
    logic [31:0] d;
    for (int w = 0; w < MAIN_WORDS; w++) begin
      busRead(16'(w * 4), d);
      check(req, d, expMain[w]);
    end
    for (int w = 0; w < INFO_WORDS; w++) begin
      busRead(16'(INFO_BASE + w * 4), d);
      check(req, d, expInfo[w]);
    end
  endtask

  function automatic logic [31:0] patA(input int w);
    return 32'hF0F0_FF00 ^ (32'(w) * 32'h0103_0507);
  endfunction

  function automatic logic [31:0] patB(input int w);
    return ~(32'(w) * 32'h0011_0011);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cnt;
    for (int w = 0; w < MAIN_WORDS; w++) expMain[w] = '1;
    for (int w = 0; w < INFO_WORDS; w++) expInfo[w] = '1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    busRead(R_READY, d);  check("R1 ready", d, 32'd1);
    busRead(R_READY2, d); check("R1 ready mirror", d, 32'd1);
    busRead(R_CFG, d);    check("R1 mode", d, 32'd0);
    checkArray("R1 erased after reset");

    // R2 mode field sweep, R10 one-cycle read
    for (int m = 0; m < 4; m++) begin
      busWrite(R_CFG, 32'hFFFF_FFF0 | 32'(m));
      busRead(R_CFG, d);
      check("R2 R10 mode readback", d, 32'(m));
    end

    // R3/R4 program every word, count busy polls
    busWrite(R_CFG, 32'd1);
    for (int w = 0; w < MAIN_WORDS; w++) begin
      busWrite(16'(w * 4), patA(w));
      expMain[w] &= patA(w);
      busRead(R_READY2, d);
      check("R4 mirror busy", d, 32'd0);
      pollBusy(cnt);
      check("R4 program busy length", 32'(cnt + 1), 32'(PROG_CYCLES));
    end
    for (int w = 0; w < INFO_WORDS; w++) begin
      busWrite(16'(INFO_BASE + w * 4), patA(w + 7));
      expInfo[w] &= patA(w + 7);
      pollBusy(cnt);
      check("R4 info program busy length", 32'(cnt), 32'(PROG_CYCLES));
    end
    checkArray("R3 first program");
    for (int w = 0; w < MAIN_WORDS; w++) begin
      busWrite(16'(w * 4), patB(w));
      expMain[w] &= patB(w);
      pollBusy(cnt);
    end
    checkArray("R3 reprogram only clears bits");

    // R8 program outside program mode
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      busWrite(R_CFG, 32'(m));
      busWrite(16'h0000, 32'h0);
      busRead(R_READY, d); check("R8 program ignored ready", d, 32'd1);
      busRead(16'h0000, d); check("R8 program ignored data", d, expMain[0]);
    end
    // R8 erases outside erase mode
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      busWrite(R_CFG, 32'(m));
      busWrite(R_PGER, 32'd0);
      busRead(R_READY, d); check("R8 page erase ignored", d, 32'd1);
      busWrite(R_ALLER, 32'd1);
      busRead(R_READY, d); check("R8 full erase ignored", d, 32'd1);
      busWrite(R_INFER, 32'd1);
      busRead(R_READY, d); check("R8 info erase ignored", d, 32'd1);
    end
    checkArray("R8 array unchanged");

    // R9 back-to-back requests while busy
    busWrite(R_CFG, 32'd1);
    expMain[5] &= 32'h0F0F_0F0F;
    busWrite(16'd20, 32'h0F0F_0F0F);
    busWrite(16'd24, 32'h0);
    pollBusy(cnt);
    check("R9 busy window unchanged", 32'(cnt), 32'(PROG_CYCLES - 1));
    busRead(16'd24, d); check("R9 program while busy dropped", d, expMain[6]);
    busWrite(R_CFG, 32'd2);
    busWrite(R_PGER, 32'd40);
    busWrite(R_ALLER, 32'd1);
    for (int w = PAGE_WORDS; w < 2 * PAGE_WORDS; w++) expMain[w] = '1;
    pollBusy(cnt);
    check("R9 full erase while busy dropped", 32'(cnt), 32'(PAGE_CYCLES - 1));
    checkArray("R9 array after dropped requests");

    // R5 page erase sweep, address inside page
    for (int p = 0; p < NUM_PAGES; p++) begin
      busWrite(R_PGER, 32'(p * PAGE_BYTES + 4 * (p + 1)));
      for (int w = 0; w < PAGE_WORDS; w++) expMain[p * PAGE_WORDS + w] = '1;
      pollBusy(cnt);
      check("R5 page erase busy length", 32'(cnt), 32'(PAGE_CYCLES));
      checkArray("R5 page erase contents");
    end
    busWrite(R_PGER, 32'(NUM_PAGES * PAGE_BYTES));
    busRead(R_READY, d); check("R5 out of range address ignored", d, 32'd1);

    // R7 info erase
    busWrite(R_CFG, 32'd1);
    busWrite(16'd8, 32'h1234_5678); expMain[2] &= 32'h1234_5678; pollBusy(cnt);
    busWrite(16'(INFO_BASE + 4), 32'h0); expInfo[1] = 32'h0; pollBusy(cnt);
    busWrite(R_CFG, 32'd2);
    busWrite(R_INFER, 32'd0);
    busRead(R_READY, d); check("R7 bit0 clear ignored", d, 32'd1);
    busWrite(R_INFER, 32'd1);
    for (int w = 0; w < INFO_WORDS; w++) expInfo[w] = '1;
    pollBusy(cnt);
    check("R7 info erase busy length", 32'(cnt), 32'(PAGE_CYCLES));
    checkArray("R7 only info erased");

    // R6 full erase
    busWrite(R_CFG, 32'd1);
    busWrite(16'd100, 32'h0); expMain[25] = 32'h0; pollBusy(cnt);
    busWrite(16'(INFO_BASE + 8), 32'hAAAA_0000); expInfo[2] = 32'hAAAA_0000; pollBusy(cnt);
    busWrite(R_CFG, 32'd2);
    busWrite(R_ALLER, 32'hFFFF_FFFE);
    busRead(R_READY, d); check("R6 bit0 clear ignored", d, 32'd1);
    checkArray("R6 nothing erased by bit0 clear");
    busWrite(R_ALLER, 32'd1);
    for (int w = 0; w < MAIN_WORDS; w++) expMain[w] = '1;
    for (int w = 0; w < INFO_WORDS; w++) expInfo[w] = '1;
    pollBusy(cnt);
    check("R6 full erase busy length", 32'(cnt), 32'(FULL_CYCLES));
    checkArray("R6 full erase contents");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule